// File: doc/BRIEF.md
# Serial-Bus GPIO Expander Register Slave

This block is the serial-bus target side of an 8-bit general-purpose I/O expander. It follows the two-wire bus using the system clock. It recognises START and STOP conditions and shifts bytes in and out. It acknowledges bytes that are addressed to it and keeps a small register file. That register file holds the output levels, a per-bit read-inversion mask and a per-bit direction mask. The block drives the data line only through an open-drain output enable. A high enable pulls the line low.

A write transaction carries three kinds of byte, in this order. The first is the address byte. The second is a command byte, which sets a register pointer. Every byte after that is data for the register the pointer selects. The pointer never advances by itself. Any number of data bytes, and any later read transaction, use the same register until a new command byte arrives. A read of the input port returns the live pin levels after the inversion mask is applied. Each time input-port data is handed to the transmit shifter, the block raises a one-cycle strobe so that separate interrupt logic can re-arm.

Top module: `gpio_xpndr_slave`

## Requirements
- R1: The first byte after a START is the 7-bit target address (bits 7..1) followed by a direction bit (bit 0, 1 = read, 0 = write). When the address equals `DEV_ADDR`, the block pulls SDA low on the ninth clock. When it does not, SDA is never driven until the next START.
- R2: In a write transaction the byte after the address byte sets the pointer. Pointer value 1 selects the output register, 2 the inversion mask and 3 the direction mask. A data byte written through one of these pointers appears on the matching port.
- R3: Pointer value 0 selects the input port, which is read-only. Data bytes written to it change no register.
- R4: The pointer does not auto-increment. Successive data bytes in one write all land in the same register, and successive bytes of a read all return that same register.
- R5: After reset the output register is 0xFF, the inversion mask is 0x00 and the direction mask is 0xFF, and SDA is released.
- R6: A read through pointer 1, 2 or 3 returns the stored register value, whatever the pin levels are.
- R7: A read through pointer 0 returns the pin levels XOR the inversion mask, sampled when the byte is loaded for transmission.
- R8: Every byte the block receives while addressed is acknowledged. During a read, a master NACK ends the transfer, and SDA is then left released so that the master can issue STOP.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The block changes SDA only while SCL is low. A repeated START restarts the address phase. A STOP in the middle of a byte discards that byte.
- R10: A pointer value above 3 is acknowledged but selects nothing. Writes through it are dropped, and reads through it return 0x00.
- R11: `inport_rd_stb` is high for exactly one cycle each time an input-port byte is loaded for transmission, and never for any other pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_in | input | 8 | Present levels on the expander pins |
| out_reg | output | 8 | Output register value |
| pol_reg | output | 8 | Read-inversion mask |
| cfg_reg | output | 8 | Direction mask, 1 = input |
| inport_rd_stb | output | 1 | One-cycle pulse when input-port data is loaded |

## Verification
The checker watches four things on every cycle. SDA is never newly pulled low while the synchronized SCL is high. A register changes only in the cycle after a write aimed at it. A write through pointer 0 or through a pointer above 3 leaves all three registers unchanged. The input-port strobe lasts one cycle and occurs only while the pointer is 0.

Some properties are only visible in whole transactions, so the bench's scenarios must show them:
- the acknowledge pattern for a matching and a non-matching address;
- the absence of auto-increment over multi-byte transfers;
- the pin-XOR-mask read value;
- the release of SDA after a master NACK;
- the effect of a repeated START;
- a STOP arriving mid-byte.

// File: rtl/gx_pkg.sv
package gx_pkg;

  localparam int unsigned GX_DW      = 8;
  localparam int unsigned GX_NREG    = 4;
  localparam int unsigned GX_IDX_POL = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } gx_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } gx_phase_e;

  function automatic logic [GX_DW-1:0] gx_rst_val(input int idx);
    case (idx)
      1:       return '1;
      3:       return '1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/gx_sync_edge.sv
module gx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
#(
  parameter int unsigned DW   = GX_DW,
  parameter int unsigned NREG = GX_NREG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_ptr,
  input  logic [DW-1:0]            wr_data,
  input  logic [DW-1:0]            rd_ptr,
  input  logic [DW-1:0]            pin_in,
  output logic [NREG-1:0][DW-1:0]  bank_o,
  output logic [DW-1:0]            rd_data
);

  localparam int unsigned IW = $clog2(NREG);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (gi == 0) begin : g_ro
      assign bank_o[gi] = '0;
    end else begin : g_rw
      logic          hit;
      logic [DW-1:0] val_q;
      logic [DW-1:0] val_d;

      assign hit = wr_en && (wr_ptr == DW'(gi));

      always_comb begin
        val_d = val_q;
        if (hit) val_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= gx_rst_val(gi);
        else        val_q <= val_d;
      end

      assign bank_o[gi] = val_q;
    end
  end

  logic          in_range;
  logic [IW-1:0] sel;

  assign in_range = (rd_ptr >> IW) == '0;
  assign sel      = rd_ptr[IW-1:0];

  always_comb begin
    if (!in_range)         rd_data = '0;
    else if (sel == '0)    rd_data = pin_in ^ bank_o[GX_IDX_POL];
    else                   rd_data = bank_o[sel];
  end

endmodule

// File: rtl/gx_proto.sv
module gx_proto
  import gx_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h20,
  parameter int unsigned DW       = GX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] ptr_o,
  output logic          sda_oe,
  output logic          inport_rd
);

  localparam int unsigned CW = $clog2(DW) + 1;

  gx_state_e     st_q, st_d;
  gx_phase_e     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          nack_q, nack_d;
  logic          load;
  logic          strobe_q, strobe_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    nack_d = nack_q;
    wr_en  = 1'b0;
    load   = 1'b0;
    if (stop_ev) begin
      st_d = ST_IDLE;
    end else if (start_ev) begin
      st_d  = ST_RX;
      ph_d  = PH_ADDR;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != CW'(DW)) begin
            sh_d  = {sh_q[DW-2:0], sda};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == DEV_ADDR) begin
                  rw_d = sh_q[0];
                  st_d = ST_RACK;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              PH_CMD: begin
                ptr_d = sh_q;
                st_d  = ST_RACK;
              end
              default: begin
                wr_en = 1'b1;
                st_d  = ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (ph_q == PH_ADDR && rw_q) begin
              st_d = ST_TX;
              tx_d = rd_data;
              load = 1'b1;
            end else begin
              st_d = ST_RX;
              ph_d = (ph_q == PH_ADDR) ? PH_CMD : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW - 1)) begin
              st_d = ST_MACK;
            end else begin
              tx_d  = {tx_q[DW-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_IDLE;
            end else begin
              st_d  = ST_TX;
              tx_d  = rd_data;
              load  = 1'b1;
              cnt_d = '0;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  assign strobe_d = load && (ptr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_ADDR;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      rw_q     <= rw_d;
      nack_q   <= nack_d;
      strobe_q <= strobe_d;
    end
  end

  assign wr_data   = sh_q;
  assign ptr_o     = ptr_q;
  assign sda_oe    = (st_q == ST_RACK) || (st_q == ST_TX && !tx_q[DW-1]);
  assign inport_rd = strobe_q;

endmodule

// File: rtl/gpio_xpndr_slave.sv
module gpio_xpndr_slave
  import gx_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [GX_DW-1:0] pin_in,
  output logic [GX_DW-1:0] out_reg,
  output logic [GX_DW-1:0] pol_reg,
  output logic [GX_DW-1:0] cfg_reg,
  output logic             inport_rd_stb
);

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_ev, stop_ev;

  gx_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i),
    .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  gx_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i),
    .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_ev = sda_fall & scl_s;
  assign stop_ev  = sda_rise & scl_s;

  logic                         wr_en;
  logic [GX_DW-1:0]             wr_data;
  logic [GX_DW-1:0]             cmd_ptr;
  logic [GX_DW-1:0]             rd_data;
  logic [GX_NREG-1:0][GX_DW-1:0] bank;

  gx_proto #(.DEV_ADDR(DEV_ADDR), .DW(GX_DW)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_o(cmd_ptr), .sda_oe(sda_oe), .inport_rd(inport_rd_stb)
  );

  gx_regs #(.DW(GX_DW), .NREG(GX_NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(cmd_ptr),
    .wr_data(wr_data), .rd_ptr(cmd_ptr), .pin_in(pin_in),
    .bank_o(bank), .rd_data(rd_data)
  );

  assign out_reg = bank[1];
  assign pol_reg = bank[2];
  assign cfg_reg = bank[3];

endmodule

// File: rtl/gx_chk.sv
module gx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       inport_rd,
  input logic       wr_en,
  input logic [7:0] ptr,
  input logic [7:0] out_reg,
  input logic [7:0] pol_reg,
  input logic [7:0] cfg_reg
);

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_out_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_reg) |-> $past(wr_en && ptr == 8'd1));

  assert_pol_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_reg) |-> $past(wr_en && ptr == 8'd2));

  assert_cfg_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_reg) |-> $past(wr_en && ptr == 8'd3));

  assert_ro_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == 8'd0) |=> ($stable(out_reg) && $stable(pol_reg) && $stable(cfg_reg)));

  assert_badcmd_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr > 8'd3) |=> ($stable(out_reg) && $stable(pol_reg) && $stable(cfg_reg)));

  assert_stb_ptr0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inport_rd |-> ptr == 8'd0);

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inport_rd |=> !inport_rd);

endmodule

bind gpio_xpndr_slave gx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .inport_rd(inport_rd_stb), .wr_en(wr_en), .ptr(cmd_ptr),
  .out_reg(out_reg), .pol_reg(pol_reg), .cfg_reg(cfg_reg)
);

// File: tb/gpio_xpndr_slave_tb_top.sv
module gpio_xpndr_slave_tb_top;

  localparam logic [6:0] ADDR = 7'h20;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [7:0] pins = 8'h00;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] out_reg, pol_reg, cfg_reg;
  logic       stb;

  int errors = 0;
  int checks = 0;
  int stb_cnt = 0;
  int oe_seen = 0;
  logic watch_oe = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  gpio_xpndr_slave #(.DEV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pin_in(pins), .out_reg(out_reg),
    .pol_reg(pol_reg), .cfg_reg(cfg_reg), .inport_rd_stb(stb)
  );

  always @(posedge clk) if (stb) stb_cnt <= stb_cnt + 1;
  always @(negedge clk) if (watch_oe && sda_oe) oe_seen <= oe_seen + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    wq; m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0;
  endtask

  task automatic i2c_stop;
    wq; m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic bit_out(input logic b);
    wq; m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wq; m_sda = 1'b1; wq; m_scl = 1'b1; wq; b = sda_bus; wq; m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(last);
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    i2c_start;
    send_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'd0, a}, 8'h00);
    send_byte(cmd, a);          chk("R8 cmd ack", {7'd0, a}, 8'h00);
    send_byte(d, a);            chk("R8 data ack", {7'd0, a}, 8'h00);
    i2c_stop;
  endtask

  task automatic set_ptr(input logic [7:0] cmd);
    logic a;
    i2c_start;
    send_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'd0, a}, 8'h00);
    send_byte(cmd, a);          chk("R8 cmd ack", {7'd0, a}, 8'h00);
    i2c_stop;
  endtask

  task automatic rd_one(output logic [7:0] d);
    logic a;
    i2c_start;
    send_byte({ADDR, 1'b1}, a); chk("R1 read addr ack", {7'd0, a}, 8'h00);
    recv_byte(1'b1, d);
    wq;
    chk("R8 released after NACK", {7'd0, sda_oe}, 8'h00);
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d, v, a8;
    logic a;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset state
    chk("R5 out default", out_reg, 8'hFF);
    chk("R5 pol default", pol_reg, 8'h00);
    chk("R5 cfg default", cfg_reg, 8'hFF);
    chk("R5 sda released", {7'd0, sda_oe}, 8'h00);
    rd_one(d);
    chk("R5 readback out via default ptr0", d, pins ^ 8'h00);

    // R2 / R6 register write and readback sweep
    pins = 8'hA5;
    for (int r = 1; r <= 3; r++) begin
      for (int k = 0; k < 16; k++) begin
        v = 8'(k * 17 + r);
        wr_reg(8'(r), v);
        a8 = (r == 1) ? out_reg : (r == 2) ? pol_reg : cfg_reg;
        chk("R2 port value", a8, v);
        rd_one(d);
        chk("R6 stored readback", d, v);
      end
    end
    wr_reg(8'd2, 8'h00);

    // R7 / R11 input port sweep
    for (int p = 0; p < 4; p++) begin
      v = 8'(8'h0F << (p * 2)) ^ 8'(p);
      wr_reg(8'd2, v);
      set_ptr(8'd0);
      for (int k = 0; k < 16; k++) begin
        pins = 8'(k * 29 + 3);
        s0 = stb_cnt;
        rd_one(d);
        chk("R7 pin xor mask", d, pins ^ v);
        chk("R11 one strobe per byte", 8'(stb_cnt - s0), 8'd1);
      end
    end

    // R4 no auto-increment on writes and reads
    wr_reg(8'd1, 8'h3C);
    i2c_start;
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd2, a);
    send_byte(8'h11, a); chk("R8 multi ack", {7'd0, a}, 8'h00);
    send_byte(8'h22, a); chk("R8 multi ack", {7'd0, a}, 8'h00);
    send_byte(8'h33, a); chk("R8 multi ack", {7'd0, a}, 8'h00);
    i2c_stop;
    chk("R4 last byte kept", pol_reg, 8'h33);
    chk("R4 neighbour untouched", out_reg, 8'h3C);
    chk("R4 cfg untouched", cfg_reg, 8'hFF - 8'hFF + 8'(15 * 17 + 3));
    s0 = stb_cnt;
    i2c_start;
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b0, d); chk("R4 read repeat 1", d, 8'h33);
    recv_byte(1'b0, d); chk("R4 read repeat 2", d, 8'h33);
    recv_byte(1'b1, d); chk("R4 read repeat 3", d, 8'h33);
    i2c_stop;
    chk("R11 no strobe for ptr2", 8'(stb_cnt - s0), 8'd0);

    // R11 multi-byte input read
    set_ptr(8'd0);
    pins = 8'h5A;
    s0 = stb_cnt;
    i2c_start;
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b0, d); chk("R7 multi read", d, 8'h5A ^ 8'h33);
    recv_byte(1'b1, d); chk("R7 multi read", d, 8'h5A ^ 8'h33);
    i2c_stop;
    chk("R11 two strobes", 8'(stb_cnt - s0), 8'd2);

    // R3 write to input port ignored
    wr_reg(8'd0, 8'hC3);
    chk("R3 out unchanged", out_reg, 8'h3C);
    chk("R3 pol unchanged", pol_reg, 8'h33);
    chk("R3 cfg unchanged", cfg_reg, 8'(15 * 17 + 3));
    rd_one(d);
    chk("R3 input still pins", d, 8'h5A ^ 8'h33);

    // R10 out-of-range pointers
    for (int c = 4; c < 8; c++) begin
      wr_reg(8'(c), 8'h00);
      chk("R10 out unchanged", out_reg, 8'h3C);
      chk("R10 pol unchanged", pol_reg, 8'h33);
      chk("R10 cfg unchanged", cfg_reg, 8'(15 * 17 + 3));
      rd_one(d);
      chk("R10 reads zero", d, 8'h00);
    end

    // R1 address mismatch: no drive
    oe_seen = 0;
    watch_oe = 1'b1;
    i2c_start;
    send_byte({7'h21, 1'b0}, a); chk("R1 mismatch no ack", {7'd0, a}, 8'h01);
    send_byte(8'd1, a);
    send_byte(8'h00, a);
    i2c_stop;
    i2c_start;
    send_byte({7'h60, 1'b1}, a); chk("R1 mismatch read no ack", {7'd0, a}, 8'h01);
    recv_byte(1'b1, d);
    chk("R1 mismatch bus idle", d, 8'hFF);
    i2c_stop;
    watch_oe = 1'b0;
    chk("R1 never drove", 8'(oe_seen), 8'd0);
    chk("R1 out unchanged", out_reg, 8'h3C);

    // R9 repeated start restarts address phase
    i2c_start;
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd3, a);
    i2c_start;
    send_byte({ADDR, 1'b1}, a); chk("R9 rstart ack", {7'd0, a}, 8'h00);
    recv_byte(1'b1, d);
    chk("R9 rstart reads cfg", d, 8'(15 * 17 + 3));
    i2c_stop;

    // R9 stop mid-byte discards
    i2c_start;
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd1, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    i2c_stop;
    chk("R9 aborted byte dropped", out_reg, 8'h3C);
    chk("R9 idle after stop", {7'd0, sda_oe}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule